// File: doc/BRIEF.md
# Table-Driven Register Write Sequencer

The block walks a configuration table stored in a synchronous read port and turns it into a series of single-beat register writes. The table is a flat stream of 32-bit words. The first word gives the starting target address. Each later word is handled in one of three ways:

- an ordinary word is written to the current target, and the target then moves up by one stride of 4 bytes;
- a word that matches the jump marker makes the next table word the new target;
- a word that matches the stop marker ends the walk.

Software loads the base bound and the two marker values, then pulses `start`. When the walk ends, the block reports either a one-cycle completion pulse or one of two sticky error flags. The flags stay set until the next accepted start.

Top module: `tbl_init_seq`

## Requirements
- R1: After an accepted start, the first table word read (table index 0) is loaded as the target address. No write is issued for it.
- R2: A word that matches neither marker is written once to the current target. The target then advances by 4 for the next ordinary word.
- R3: A word equal to `end_mark` ends the walk without a write. `done` is high for exactly one cycle, and `busy` drops in that same cycle.
- R4: A word equal to `jump_mark` causes the following table word to become the new target address. No write is issued for either of the two words.
- R5: Before each data word is fetched, the target is compared with `base_addr`, unsigned. If the target is smaller, the walk stops without a further fetch or write, and `err_below` is set and held.
- R6: `wr_valid` stays high, with `wr_addr` and `wr_data` unchanged, until a cycle in which `wr_ready` is high. Exactly one write is counted per such cycle.
- R7: At most `MAX_WORDS` table words are fetched per walk. If another fetch would be needed, the walk stops and `err_len` is set and held.
- R8: A start accepted while idle clears `err_below` and `err_len` and restarts reading at index 0. A start pulse while `busy` is high has no effect on the walk.
- R9: If both markers hold the same value, the word counts as the stop marker. If the bound check and the length limit fail on the same fetch, only `err_below` is raised.
- R10: Out of reset, `busy`, `wr_valid`, `tbl_rd_en`, `done`, `err_below` and `err_len` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| base_addr | input | 32 | Lowest permitted target address |
| end_mark | input | 32 | Word value that ends the table |
| jump_mark | input | 32 | Word value announcing a new target address |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_addr | output | $clog2(MAX_WORDS) | Table word index |
| tbl_rd_data | input | 32 | Table word, valid one cycle after the request |
| wr_valid | output | 1 | Write request |
| wr_addr | output | 32 | Write target address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted when high together with wr_valid |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse on a normal end |
| err_below | output | 1 | Sticky: target fell below the base bound |
| err_len | output | 1 | Sticky: table ran past MAX_WORDS without a stop marker |

## Verification
The bound check and the length limit can fail on the same fetch. The bench provokes this with a table exactly `MAX_WORDS` long whose last word, reached through a jump marker, is an address below the base. The walk must then report only the bound error, with no extra fetch. A second collision makes both marker values equal, and the run must end with `done` rather than taking a jump. Around these directed cases, randomly built tables with random ready stalls are compared with a bench-side walk of the same table. The comparison covers the write list, the outcome and the fetch count.

// File: rtl/tbl_seq_pkg.sv
package tbl_seq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 32;
  localparam int STRIDE = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_FETCH  = 2'd1,
    S_DECODE = 2'd2,
    S_WRITE  = 2'd3
  } seq_state_t;

  // target address after one ordinary write
  function automatic addr_t addr_step(input addr_t a);
    return a + addr_t'(STRIDE);
  endfunction

  // unsigned lower-bound violation test
  function automatic logic addr_below(input addr_t a, input addr_t bound);
    return (a < bound);
  endfunction
endpackage

// File: rtl/tbl_classify.sv
module tbl_classify
  import tbl_seq_pkg::*;
(
  input  word_t word_in,
  input  word_t end_mark,
  input  word_t jump_mark,
  output logic  is_end,
  output logic  is_jump
);
  // stop marker takes priority when both markers are equal (R9)
  always_comb begin
    is_end  = (word_in == end_mark);
    is_jump = (word_in == jump_mark) && !is_end;
  end
endmodule

// File: rtl/tbl_fetch_ctr.sv
module tbl_fetch_ctr #(
  parameter int MAX_WORDS = 64,
  localparam int PW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [PW-1:0] ptr,
  output logic          exhausted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clear) ptr <= '0;
    else if (step)  ptr <= ptr + PW'(1);
  end

  assign exhausted = (ptr == PW'(MAX_WORDS));

  p_ptr_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(MAX_WORDS));
  p_no_step_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> !step);
endmodule

// File: rtl/tbl_wr_port.sv
module tbl_wr_port
  import tbl_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_addr,
  input  word_t load_data,
  input  logic  wr_ready,
  output logic  wr_valid,
  output addr_t wr_addr,
  output word_t wr_data,
  output logic  accept
);
  assign accept = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= load_addr;
      wr_data  <= load_data;
    end else if (accept) begin
      wr_valid <= 1'b0;
    end
  end

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  p_no_reload_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !load);
endmodule

// File: rtl/tbl_init_seq.sv
module tbl_init_seq
  import tbl_seq_pkg::*;
#(
  parameter int MAX_WORDS = 64,
  localparam int TW = $clog2(MAX_WORDS),
  localparam int PW = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   base_addr,
  input  logic [31:0]   end_mark,
  input  logic [31:0]   jump_mark,
  output logic          tbl_rd_en,
  output logic [TW-1:0] tbl_rd_addr,
  input  logic [31:0]   tbl_rd_data,
  output logic          wr_valid,
  output logic [31:0]   wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done,
  output logic          err_below,
  output logic          err_len
);
  seq_state_t    state;
  logic          need_addr;
  addr_t         cur_addr;
  logic          done_q, err_below_q, err_len_q;
  logic [PW-1:0] ptr;
  logic          exhausted;
  logic          is_end, is_jump;

  // named internal events
  logic launch, ev_bound_fail, ev_len_fail, ev_end, ev_jump;
  logic ev_write_load, ev_addr_load, ev_write_accept;

  tbl_classify u_classify (
    .word_in  (tbl_rd_data),
    .end_mark (end_mark),
    .jump_mark(jump_mark),
    .is_end   (is_end),
    .is_jump  (is_jump)
  );

  tbl_fetch_ctr #(.MAX_WORDS(MAX_WORDS)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .step     (tbl_rd_en),
    .ptr      (ptr),
    .exhausted(exhausted)
  );

  tbl_wr_port u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_write_load),
    .load_addr(cur_addr),
    .load_data(tbl_rd_data),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .accept   (ev_write_accept)
  );

  always_comb begin
    launch        = start && (state == S_IDLE);
    ev_bound_fail = (state == S_FETCH) && !need_addr && addr_below(cur_addr, base_addr);
    ev_len_fail   = (state == S_FETCH) && !ev_bound_fail && exhausted;
    tbl_rd_en     = (state == S_FETCH) && !ev_bound_fail && !exhausted;
    ev_addr_load  = (state == S_DECODE) && need_addr;
    ev_end        = (state == S_DECODE) && !need_addr && is_end;
    ev_jump       = (state == S_DECODE) && !need_addr && is_jump;
    ev_write_load = (state == S_DECODE) && !need_addr && !is_end && !is_jump;
  end

  assign tbl_rd_addr = ptr[TW-1:0];
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign err_below   = err_below_q;
  assign err_len     = err_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      need_addr   <= 1'b1;
      cur_addr    <= '0;
      done_q      <= 1'b0;
      err_below_q <= 1'b0;
      err_len_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (launch) begin
          state       <= S_FETCH;
          need_addr   <= 1'b1;
          err_below_q <= 1'b0;
          err_len_q   <= 1'b0;
        end
        S_FETCH: begin
          if (ev_bound_fail) begin
            err_below_q <= 1'b1;
            state       <= S_IDLE;
          end else if (ev_len_fail) begin
            err_len_q <= 1'b1;
            state     <= S_IDLE;
          end else begin
            state <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (ev_addr_load) begin
            cur_addr  <= tbl_rd_data;
            need_addr <= 1'b0;
            state     <= S_FETCH;
          end else if (ev_end) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (ev_jump) begin
            need_addr <= 1'b1;
            state     <= S_FETCH;
          end else begin
            state <= S_WRITE;
          end
        end
        S_WRITE: if (ev_write_accept) begin
          cur_addr <= addr_step(cur_addr);
          state    <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_no_low_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !addr_below(wr_addr, base_addr));
  p_err_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_below && err_len));
  p_done_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_below || err_len));
  p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (busy && !tbl_rd_en));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_below && !start) |=> err_below);
endmodule

// File: tb/test_tbl_init_seq.sv
module test_tbl_init_seq;
  localparam int MAXW = 64;
  localparam int TW = $clog2(MAXW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_addr = '0, end_mark = '0, jump_mark = '0;
  logic tbl_rd_en;
  logic [TW-1:0] tbl_rd_addr;
  logic [31:0] tbl_rd_data;
  logic wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic busy, done, err_below, err_len;

  always #2 clk = ~clk;

  tbl_init_seq #(.MAX_WORDS(MAXW)) i_tbl_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .end_mark(end_mark), .jump_mark(jump_mark), .tbl_rd_en(tbl_rd_en),
    .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .busy(busy), .done(done),
    .err_below(err_below), .err_len(err_len));

  logic [31:0] rom [0:MAXW-1];
  always_ff @(posedge clk) if (tbl_rd_en) tbl_rd_data <= rom[tbl_rd_addr];

  int n_chk = 0, n_bad = 0;
  logic [31:0] e_addr [0:MAXW-1];
  logic [31:0] e_data [0:MAXW-1];
  logic [31:0] g_addr [0:MAXW-1];
  logic [31:0] g_data [0:MAXW-1];
  int ready_pct = 70;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bench-side walk: outcome 0 done, 1 below bound, 2 length limit
  task automatic ref_walk(output int nwr, output int outcome, output int nfetch);
    int p;
    logic [31:0] a, w;
    nwr = 0; outcome = 0;
    a = rom[0]; p = 1;
    forever begin
      if (a < base_addr) begin outcome = 1; break; end
      if (p == MAXW) begin outcome = 2; break; end
      w = rom[p]; p++;
      if (w == end_mark) begin outcome = 0; break; end
      else if (w == jump_mark) begin
        if (p == MAXW) begin outcome = 2; break; end
        a = rom[p]; p++;
      end else begin
        e_addr[nwr] = a; e_data[nwr] = w; nwr++;
        a = a + 32'd4;
      end
    end
    nfetch = p;
  endtask

  task automatic run_table(input string tag, input int restart_at);
    int enwr, eout, efetch, gnwr, gfetch, ndone, cyc, first_rd, holdbad, mism;
    bit pend;
    logic [31:0] pa, pd;
    ref_walk(enwr, eout, efetch);
    gnwr = 0; gfetch = 0; ndone = 0; cyc = 0; first_rd = -1; holdbad = 0; pend = 0;
    pa = '0; pd = '0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err_below == 1'b0 && err_len == 1'b0, "R8", "flags clear after start",
        {30'd0, err_below, err_len}, 32'd0);
    forever begin
      wr_ready = (($urandom % 100) < ready_pct);
      if (cyc == restart_at) start = 1'b1; else start = 1'b0;
      if (pend && !(wr_valid && wr_addr == pa && wr_data == pd)) holdbad++;
      pend = wr_valid && !wr_ready; pa = wr_addr; pd = wr_data;
      if (wr_valid && wr_ready && gnwr < MAXW) begin
        g_addr[gnwr] = wr_addr; g_data[gnwr] = wr_data; gnwr++;
      end
      if (tbl_rd_en) begin
        if (first_rd < 0) first_rd = int'(tbl_rd_addr);
        gfetch++;
      end
      if (done) ndone++;
      if (!busy || cyc > 4000) break;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc <= 4000, tag, "walk finished", cyc, 4000);
    chk(first_rd == 0, "R1 R8", "first fetch index", first_rd, 0);
    chk(err_below == (eout == 1), "R5", "err_below", err_below, (eout == 1));
    chk(err_len == (eout == 2), "R7", "err_len", err_len, (eout == 2));
    chk(ndone == (eout == 0 ? 1 : 0), "R3", "done pulses", ndone, (eout == 0));
    chk(gnwr == enwr, "R2 R4", "write count", gnwr, enwr);
    chk(gfetch == efetch, "R5 R7", "fetch count", gfetch, efetch);
    mism = 0;
    for (int k = 0; k < enwr && k < gnwr; k++)
      if (g_addr[k] != e_addr[k] || g_data[k] != e_data[k]) mism++;
    chk(mism == 0, tag, "write list mismatches", mism, 0);
    chk(holdbad == 0, "R6", "held request changed", holdbad, 0);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done drops after one cycle", done, 0);
  endtask

  task automatic fill_data(input int from, input int to);
    for (int k = from; k <= to; k++) rom[k] = $urandom | 32'h0000_0001;
  endtask

  task automatic random_table();
    int r;
    rom[0] = base_addr + ($urandom % 32'h400) - 32'h40;
    for (int k = 1; k < MAXW; k++) begin
      r = $urandom % 20;
      if (r == 0) rom[k] = end_mark;
      else if (r < 3) begin
        rom[k] = jump_mark;
        if (k + 1 < MAXW) begin k++; rom[k] = base_addr + ($urandom % 32'h400) - 32'h30; end
      end else rom[k] = $urandom;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < MAXW; k++) rom[k] = '0;
    base_addr = 32'h1000_0000; end_mark = 32'hFFFF_FFFF; jump_mark = 32'hFFFF_FFFE;
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid && !tbl_rd_en && !done && !err_below && !err_len, "R10",
        "reset state", {26'd0, busy, wr_valid, tbl_rd_en, done, err_below, err_len}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: plain writes then stop marker
    rom[0] = 32'h1000_0100; rom[1] = 32'hA1; rom[2] = 32'hA2; rom[3] = 32'hA3;
    rom[4] = end_mark;
    run_table("R2", -1);
    chk(g_addr[2] == 32'h1000_0108, "R2", "third write address", g_addr[2], 32'h1000_0108);

    // R4: jump marker
    rom[0] = 32'h1000_0000; rom[1] = 32'h11; rom[2] = jump_mark; rom[3] = 32'h1000_2000;
    rom[4] = 32'h22; rom[5] = 32'h33; rom[6] = end_mark;
    run_table("R4", -1);
    chk(g_addr[1] == 32'h1000_2000, "R4", "address after jump", g_addr[1], 32'h1000_2000);

    // R5: start below base, and below after jump
    rom[0] = 32'h0FFF_FFFC; rom[1] = 32'h55; rom[2] = end_mark;
    run_table("R5", -1);
    rom[0] = 32'h1000_0000; rom[1] = 32'h66; rom[2] = jump_mark; rom[3] = 32'h0000_0010;
    rom[4] = 32'h77; rom[5] = end_mark;
    run_table("R5", -1);

    // R8: fresh start clears flag; start while busy ignored
    rom[0] = 32'h1000_0040; fill_data(1, 20); rom[21] = end_mark;
    run_table("R8", 6);

    // R7: no stop marker within MAXW words
    rom[0] = 32'h1000_0000; fill_data(1, MAXW - 1);
    run_table("R7", -1);

    // R9: markers equal -> stop wins
    jump_mark = end_mark;
    rom[0] = 32'h1000_0000; rom[1] = 32'h99; rom[2] = end_mark; rom[3] = 32'h1000_0800;
    rom[4] = 32'h98; rom[5] = 32'h1234_0000;
    run_table("R9", -1);
    jump_mark = 32'hFFFF_FFFE;

    // R9: bound and length fail on same fetch -> bound wins
    rom[0] = 32'h1000_0000; fill_data(1, MAXW - 3);
    rom[MAXW-2] = jump_mark; rom[MAXW-1] = 32'h0000_0100;
    run_table("R9", -1);

    // R6: write port under full stall pressure
    ready_pct = 15;
    rom[0] = 32'h1000_0000; fill_data(1, 8); rom[9] = end_mark;
    run_table("R6", -1);

    // random tables
    for (int t = 0; t < 150; t++) begin
      ready_pct = 30 + int'($urandom % 70);
      base_addr = $urandom & 32'hFFFF_F000 | 32'h0000_1000;
      end_mark = 32'hDEAD_0000 | ($urandom % 16);
      jump_mark = 32'hBEEF_0000 | ($urandom % 16);
      random_table();
      run_table("R2 R4 R5", (t % 7 == 0) ? 3 : -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule